// File: doc/BRIEF.md
# Power-of-two probability coin generator

This block turns a counter value into one biased coin toss. For a count c the ideal chance of heads is 1/(c+1), but the hardware only has fair random bits. The block therefore picks the exponent N = floor(log2(c+1)) and reports heads only when N fresh fair bits are all ones. The realised chance is then exactly 2^-N. That value is never below the ideal and never more than twice it.

A caller presents a count with a one-cycle request strobe. One clock later a result strobe appears together with the heads flag. Requests may arrive on every cycle. A free-running 32-bit linear feedback shift register supplies the fair bits. It replaces its whole word on every clock, so no bit is used by two requests. Counts whose exponent is larger than a parameter limit always give tails.

Top module: `coin_pow2`

## Requirements
- R1: The exponent N is the position of the most significant set bit of c+1, where c+1 is formed one bit wider than the count. Every count from 2^N-1 up to 2^(N+1)-2 therefore shares the same N. The realised heads chance 2^-N lies in [1/(c+1), 2/(c+1)).
- R2: For an accepted request with N not above MAX_N, the heads flag is 1 exactly when bits N-1 down to 0 of the generator word held in the request cycle are all 1.
- R3: A count of 0 gives N = 0 and always yields heads.
- R4: When N is greater than MAX_N (default 31), the result is tails. With the default 32-bit count, this applies only to c = 32'hFFFF_FFFF.
- R5: The generator word resets to SEED (default 32'hACE1_2024). On every clock after reset it advances by 32 single steps. One step shifts the word left by one and loads bit 0 with the XOR of bits 31, 21, 1 and 0. The word in use therefore changes completely on every cycle.
- R6: res_valid is req_valid delayed by one clock, and it is 0 during reset.
- R7: res_heads is 0 in every cycle where res_valid is 0.
- R8: Over many requests with the same count, the fraction of heads comes close to 2^-N. For example, c = 5 gives about one quarter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one toss per cycle in which it is high |
| req_count | input | CNT_W | Counter value c for the request |
| res_valid | output | 1 | Result strobe, one cycle after req_valid |
| res_heads | output | 1 | 1 when the toss came up heads |

## Verification
The first pattern sweeps counts on both sides of every power of two (2^k-2, 2^k-1 and 2^k). It separates an exponent computed from c+1 from one computed from c, and it catches off-by-one errors in the mask. Count 0 and the all-ones count cover the forced-heads and forced-tails ends. Back-to-back requests mixed with random gaps and random magnitudes check that each toss uses the generator word of its own cycle, compared cycle by cycle against a behavioural model. A long run of one count confirms that the heads rate sits near 2^-N and not near the ideal 1/(c+1).

// File: rtl/coin_pkg.sv
package coin_pkg;
    localparam int GEN_W = 32;

    typedef struct packed {
        logic vld;
        logic heads;
    } coin_out_t;
endpackage

// File: rtl/coin_lfsr.sv
module coin_lfsr
    import coin_pkg::*;
#(
    parameter logic [GEN_W-1:0] SEED  = 32'hACE1_2024,
    parameter int               STEPS = GEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [GEN_W-1:0] word_o
);
    logic [GEN_W-1:0] state_d, state_q;

    // Advance by STEPS single shifts per clock; taps 31,21,1,0 give a maximal sequence
    always_comb begin
        state_d = state_q;
        for (int k = 0; k < STEPS; k++) begin
            state_d = {state_d[GEN_W-2:0],
                       state_d[31] ^ state_d[21] ^ state_d[1] ^ state_d[0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign word_o = state_q;
endmodule

// File: rtl/coin_exp_sel.sv
module coin_exp_sel
    import coin_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int MAX_N = 31
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [GEN_W-1:0] bits_i,
    output logic             hit_o
);
    localparam int VW = CNT_W + 1;
    localparam int NW = $clog2(VW + 1);

    logic [VW-1:0]    succ;
    logic [NW-1:0]    n_exp;
    logic             over;
    logic [GEN_W-1:0] mask;

    // Leading-one position of c+1 gives floor(log2(c+1))
    always_comb begin
        succ  = {1'b0, count_i} + VW'(1);
        n_exp = '0;
        for (int i = 0; i < VW; i++) begin
            if (succ[i]) n_exp = NW'(i);
        end
        over = (int'(n_exp) > MAX_N);
    end

    for (genvar g = 0; g < GEN_W; g++) begin : g_mask
        assign mask[g] = (int'(n_exp) > g);
    end

    assign hit_o = !over && ((bits_i & mask) == mask);
endmodule

// File: rtl/coin_pow2.sv
module coin_pow2
    import coin_pkg::*;
#(
    parameter int               CNT_W = 32,
    parameter int               MAX_N = 31,
    parameter logic [GEN_W-1:0] SEED  = 32'hACE1_2024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [CNT_W-1:0] req_count,
    output logic             res_valid,
    output logic             res_heads
);
    logic [GEN_W-1:0] gen_word;
    logic             hit;
    coin_out_t        out_d, out_q;

    coin_lfsr #(.SEED(SEED), .STEPS(GEN_W)) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_o (gen_word)
    );

    coin_exp_sel #(.CNT_W(CNT_W), .MAX_N(MAX_N)) u_sel (
        .count_i (req_count),
        .bits_i  (gen_word),
        .hit_o   (hit)
    );

    always_comb begin
        out_d       = out_q;
        out_d.vld   = req_valid;
        out_d.heads = req_valid & hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_valid = out_q.vld;
    assign res_heads = out_q.heads;
endmodule

// File: rtl/coin_pow2_chk.sv
module coin_pow2_chk #(
    parameter int CNT_W = 32,
    parameter int MAX_N = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [CNT_W-1:0] req_count,
    input logic             res_valid,
    input logic             res_heads
);
    logic [CNT_W:0] succ;
    logic           too_big;
    assign succ    = {1'b0, req_count} + (CNT_W+1)'(1);
    assign too_big = ((succ >> (MAX_N + 1)) != '0);

    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    assert_idle_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    assert_heads_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_heads |-> res_valid);
    assert_zero_heads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_count == '0) |=> res_heads);
    assert_sat_tails_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && too_big) |=> !res_heads);
endmodule

bind coin_pow2 coin_pow2_chk #(.CNT_W(CNT_W), .MAX_N(MAX_N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_count (req_count),
    .res_valid (res_valid),
    .res_heads (res_heads)
);

// File: tb/coin_pow2_bench.sv
module coin_pow2_bench;
    localparam int          MAX_N = 31;
    localparam logic [31:0] SEED  = 32'hACE1_2024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_count = '0;
    logic        res_valid, res_heads;

    int checks = 0;
    int fails  = 0;
    int heads_cnt = 0;
    bit stat_en = 0;
    bit chk_en  = 0;

    logic [31:0] ref_word;
    bit          exp_v = 0, exp_h = 0;
    string       exp_tag = "R6";

    always #4 clk = ~clk;

    coin_pow2 #(.CNT_W(32), .MAX_N(MAX_N), .SEED(SEED)) u_coin_pow2 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_count(req_count),
        .res_valid(res_valid), .res_heads(res_heads)
    );

    function automatic logic [31:0] gen_next(logic [31:0] s);
        for (int k = 0; k < 32; k++) s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
        return s;
    endfunction

    function automatic int exp_of(logic [31:0] c);
        longint v = longint'(c) + 1;
        int n = 0;
        while (v > 1) begin v = v >> 1; n++; end
        return n;
    endfunction

    function automatic bit ref_toss(logic [31:0] c, logic [31:0] s);
        int n = exp_of(c);
        if (n > MAX_N) return 0;
        for (int i = 0; i < n; i++) if (!s[i]) return 0;
        return 1;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Reference model: R5 generator, R1/R2/R3/R4 toss, R6 one-cycle delay
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_word = SEED;
            exp_v = 0; exp_h = 0; exp_tag = "R6";
        end else begin
            exp_v = req_valid;
            exp_h = req_valid && ref_toss(req_count, ref_word);
            if (!req_valid)              exp_tag = "R7";
            else if (req_count == 0)     exp_tag = "R3";
            else if (exp_of(req_count) > MAX_N) exp_tag = "R4";
            else                         exp_tag = "R1 R2 R5";
            ref_word = gen_next(ref_word);
        end
    end

    always @(negedge clk) begin
        if (chk_en) begin
            check("R6", int'(res_valid), int'(exp_v));
            check(exp_tag, int'(res_heads), int'(exp_h));
        end
        if (stat_en && res_valid && res_heads) heads_cnt++;
    end

    task automatic send(logic [31:0] c);
        req_valid = 1'b1; req_count = c;
        @(posedge clk); #2;
    endtask

    task automatic idle();
        req_valid = 1'b0; req_count = $urandom;
        @(posedge clk); #2;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 reset valid", int'(res_valid), 0);
        check("R7 reset heads", int'(res_heads), 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        chk_en = 1;

        // Small counts, back to back
        for (int r = 0; r < 20; r++)
            for (int c = 0; c <= 16; c++) send(32'(c));
        // Power-of-two boundaries, R1
        for (int k = 1; k <= 32; k++) begin
            for (int r = 0; r < 8; r++) begin
                send(32'((64'd1 << k) - 1));
                send(32'((64'd1 << k) - 2));
                send(32'(64'd1 << k));
                if (r[0]) idle();
            end
        end
        // Saturation, R4
        for (int r = 0; r < 50; r++) send(32'hFFFF_FFFF);
        // Random gaps and magnitudes
        for (int r = 0; r < 3000; r++) begin
            if ($urandom % 3 == 0) idle();
            else send($urandom >> ($urandom % 32));
        end

        // Rate check, R8 and R1: c=5 target 1/6, realised 1/4
        idle();
        stat_en = 1;
        for (int r = 0; r < 4000; r++) send(32'd5);
        idle();
        stat_en = 0;
        checks++;
        if (heads_cnt < 850 || heads_cnt > 1150) begin
            fails++;
            $display("FAIL R8: actual %0d heads expected about 1000", heads_cnt);
        end
        checks++;
        if (heads_cnt * 6 < 4000) begin
            fails++;
            $display("FAIL R1: actual %0d heads expected at least 667", heads_cnt);
        end

        idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule